// File: doc/BRIEF.md
# Root Port Request Router

This block sits at the upstream side of a root port that software sees as a PCI-to-PCI bridge. It accepts one configuration or memory request at a time. It compares the request against the port's secondary and subordinate bus numbers and against two memory windows, one prefetchable and one non-prefetchable. From that comparison it decides one of five routes. A Type 1 configuration request is passed downstream as it is, or rewritten to Type 0 for the secondary bus. A Type 0 request is claimed by the port's own register file. Any other request is answered with Unsupported Request, or is completed with all-ones data without ever leaving the port.

Requests that go downstream carry the port's own bus/device/function as requester ID. The answer comes back through a single upstream response. The block covers several cases where the port must build the answer itself: the link is down, the device number on the secondary bus is non-zero, or the downstream side returns Unsupported Request. When the downstream side returns a Configuration Request Retry Status completion, the block either shows it to software as the special Vendor ID value or reissues the request internally.

The controller is a six-state machine:
- **IDLE** moves to **ROUTE** on an accepted request.
- **ROUTE** moves to **LOCAL** for a Type 0 request, to **ISSUE** for a forward or a conversion, and to **RESP** for a synthesized answer.
- **ISSUE** moves to **RESP** for a posted memory write and to **WAIT** otherwise.
- **WAIT** moves back to **ISSUE** on a hidden retry completion and to **RESP** on any other completion.
- **LOCAL** moves to **RESP**.
- **RESP** returns to **IDLE**.

Top module: `rp_router`

## Requirements
- R1: A Type 1 config request (kind 2'b11) with bus number greater than the secondary bus and no greater than the subordinate bus is sent downstream with kind 2'b11 and bus, device, function and register unchanged, provided the link is up.
- R2: A Type 1 config request whose bus equals the secondary bus and whose device is 0 is sent downstream as Type 0 (kind 2'b10) with its other fields unchanged, provided the link is up.
- R3: A Type 0 config request (kind 2'b10) is never sent downstream. The port raises `loc_sel` for exactly one cycle and answers with the `loc_rdata` value present in that cycle, with `rsp_ur` low.
- R4: A memory request (kind 2'b00) is sent downstream when address bits [31:20] lie within either window, with base and limit both inclusive. A forwarded read returns the completion data. A forwarded write is answered with data 0 right after it is issued, without waiting for a completion.
- R5: A memory request outside both windows is not sent downstream and is answered with `rsp_ur` high and all-ones data.
- R6: A Type 1 request whose bus lies outside the range from the secondary bus to the subordinate bus, both inclusive, is not sent downstream and is answered with `rsp_ur` high and all-ones data.
- R7: `dn_req_id` is {own bus, own device, own function}. Answers built by the port carry that ID on `rsp_cpl_id`. Answers taken from a downstream completion carry that completion's `cpl_id`.
- R8: A Type 1 request to the secondary bus with a non-zero device number is not sent downstream. A read is answered with all-ones data and `rsp_ur` low; a write is answered with `rsp_ur` high.
- R9: A downstream completion with status Unsupported Request (2'b01) turns a config read into all-ones data with `rsp_ur` low. For any other request it gives all-ones data with `rsp_ur` high.
- R10: While the link is down, a config read that would go downstream is answered with all-ones data and `rsp_ur` low without being sent. A config write or memory request that would go downstream is answered with `rsp_ur` high. Type 0 requests are still claimed locally.
- R11: A retry-status completion (2'b10) to a config read of register 0, with CRS visibility enabled, is answered with 0xFFFF0001.
- R12: Any other retry-status completion causes the same request to be issued downstream again, and no upstream response is given until a completion other than a hidden retry arrives.
- R13: `req_ready` is high only while the block is idle. Each accepted request produces exactly one `rsp_valid` pulse lasting one cycle, after which the block is ready again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| own_bus | input | 8 | Port's own bus number |
| own_dev | input | 5 | Port's own device number |
| own_fn | input | 3 | Port's own function number |
| sec_bus | input | 8 | Secondary bus number |
| sub_bus | input | 8 | Subordinate bus number |
| np_base | input | 12 | Non-prefetchable window base, 1 MB units |
| np_lim | input | 12 | Non-prefetchable window limit, 1 MB units |
| pf_base | input | 12 | Prefetchable window base, 1 MB units |
| pf_lim | input | 12 | Prefetchable window limit, 1 MB units |
| link_up | input | 1 | Downstream link is up |
| crs_vis_en | input | 1 | Retry status visible to software |
| req_valid | input | 1 | Upstream request present |
| req_ready | output | 1 | Block idle, request accepted |
| req_kind | input | 2 | 00 memory, 10 config Type 0, 11 config Type 1, 01 reserved |
| req_write | input | 1 | Request is a write |
| req_bus | input | 8 | Target bus |
| req_dev | input | 5 | Target device |
| req_fn | input | 3 | Target function |
| req_reg | input | 10 | Config dword index |
| req_addr | input | 32 | Memory address |
| req_wdata | input | 32 | Write data |
| dn_valid | output | 1 | Downstream request strobe |
| dn_kind | output | 2 | Downstream request kind |
| dn_write | output | 1 | Downstream write |
| dn_bus | output | 8 | Downstream bus |
| dn_dev | output | 5 | Downstream device |
| dn_fn | output | 3 | Downstream function |
| dn_reg | output | 10 | Downstream dword index |
| dn_addr | output | 32 | Downstream memory address |
| dn_wdata | output | 32 | Downstream write data |
| dn_req_id | output | 16 | Requester ID |
| cpl_valid | input | 1 | Downstream completion strobe |
| cpl_status | input | 2 | 00 success, 01 Unsupported Request, 10 retry status |
| cpl_data | input | 32 | Completion data |
| cpl_id | input | 16 | Completer ID of the downstream completion |
| loc_sel | output | 1 | Local register access strobe |
| loc_write | output | 1 | Local access is a write |
| loc_reg | output | 10 | Local dword index |
| loc_wdata | output | 32 | Local write data |
| loc_rdata | input | 32 | Local read data |
| rsp_valid | output | 1 | Upstream response strobe |
| rsp_ur | output | 1 | Response is Unsupported Request |
| rsp_data | output | 32 | Response data |
| rsp_cpl_id | output | 16 | Completer ID of the response |

## Verification
The bench sweeps Type 1 bus numbers across every boundary of a small secondary/subordinate range, for device 0 and for a non-zero device.
- An off-by-one range compare would forward the bus just past the subordinate, or fail to convert the secondary bus.
- A missing device check would let a non-zero device leak onto the secondary link.

Memory addresses are swept across each window's base and limit pages to expose an exclusive or shifted compare. The bench also targets these error paths:
- A downstream Unsupported Request must become all-ones for config reads; a design that mixed this up would hand software an error status instead of all-ones.
- Link-down reads must return all-ones without reaching the link.
- Retry status must appear only for a Vendor ID read with visibility enabled; a wrong design would leak 0xFFFF0001 or would never reissue the request.

// File: rtl/rp_pkg.sv
package rp_pkg;

    typedef enum logic [1:0] {
        K_MEM  = 2'b00,
        K_RSVD = 2'b01,
        K_CFG0 = 2'b10,
        K_CFG1 = 2'b11
    } req_kind_e;

    typedef enum logic [1:0] {
        C_SC  = 2'b00,
        C_UR  = 2'b01,
        C_CRS = 2'b10,
        C_RSV = 2'b11
    } cpl_st_e;

    typedef enum logic [2:0] {
        RT_LOCAL,
        RT_FWD,
        RT_CONV,
        RT_UR,
        RT_ONES
    } route_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ROUTE,
        S_ISSUE,
        S_WAIT,
        S_LOCAL,
        S_RESP
    } state_e;

endpackage

// File: rtl/rp_window.sv
module rp_window #(
    parameter int WIN_W = 12
) (
    input  logic [WIN_W-1:0] page,
    input  logic [WIN_W-1:0] base,
    input  logic [WIN_W-1:0] limit,
    output logic             hit
);
    always_comb begin
        hit = (page >= base) && (page <= limit);
    end
endmodule

// File: rtl/rp_decode.sv
module rp_decode
    import rp_pkg::*;
#(
    parameter int BUS_W = 8,
    parameter int DEV_W = 5,
    parameter int WIN_W = 12,
    parameter int N_WIN = 2
) (
    input  logic [1:0]                  kind,
    input  logic                        write,
    input  logic [BUS_W-1:0]            bus,
    input  logic [DEV_W-1:0]            dev,
    input  logic [WIN_W-1:0]            page,
    input  logic                        link_up,
    input  logic [BUS_W-1:0]            sec_bus,
    input  logic [BUS_W-1:0]            sub_bus,
    input  logic [N_WIN-1:0][WIN_W-1:0] win_base,
    input  logic [N_WIN-1:0][WIN_W-1:0] win_lim,
    output route_e                      route
);
    logic [N_WIN-1:0] hit;
    req_kind_e        k;
    route_e           dead_rt;

    for (genvar g = 0; g < N_WIN; g++) begin : g_win
        rp_window #(.WIN_W(WIN_W)) u_win (
            .page (page),
            .base (win_base[g]),
            .limit(win_lim[g]),
            .hit  (hit[g])
        );
    end

    assign k       = req_kind_e'(kind);
    assign dead_rt = write ? RT_UR : RT_ONES;

    always_comb begin
        route = RT_UR;
        unique case (k)
            K_CFG0: route = RT_LOCAL;
            K_CFG1: begin
                if (bus == sec_bus) begin
                    if (!link_up || (dev != '0)) route = dead_rt;
                    else                         route = RT_CONV;
                end else if ((bus > sec_bus) && (bus <= sub_bus)) begin
                    route = link_up ? RT_FWD : dead_rt;
                end else begin
                    route = RT_UR;
                end
            end
            K_MEM:  route = ((|hit) && link_up) ? RT_FWD : RT_UR;
            K_RSVD: route = RT_UR;
        endcase
    end
endmodule

// File: rtl/rp_router.sv
module rp_router
    import rp_pkg::*;
#(
    parameter int BUS_W  = 8,
    parameter int DEV_W  = 5,
    parameter int FN_W   = 3,
    parameter int REG_W  = 10,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int GRAN   = 20,
    localparam int WIN_W = ADDR_W - GRAN,
    localparam int ID_W  = BUS_W + DEV_W + FN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_W-1:0]  own_bus,
    input  logic [DEV_W-1:0]  own_dev,
    input  logic [FN_W-1:0]   own_fn,
    input  logic [BUS_W-1:0]  sec_bus,
    input  logic [BUS_W-1:0]  sub_bus,
    input  logic [WIN_W-1:0]  np_base,
    input  logic [WIN_W-1:0]  np_lim,
    input  logic [WIN_W-1:0]  pf_base,
    input  logic [WIN_W-1:0]  pf_lim,
    input  logic              link_up,
    input  logic              crs_vis_en,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic              req_write,
    input  logic [BUS_W-1:0]  req_bus,
    input  logic [DEV_W-1:0]  req_dev,
    input  logic [FN_W-1:0]   req_fn,
    input  logic [REG_W-1:0]  req_reg,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              dn_valid,
    output logic [1:0]        dn_kind,
    output logic              dn_write,
    output logic [BUS_W-1:0]  dn_bus,
    output logic [DEV_W-1:0]  dn_dev,
    output logic [FN_W-1:0]   dn_fn,
    output logic [REG_W-1:0]  dn_reg,
    output logic [ADDR_W-1:0] dn_addr,
    output logic [DATA_W-1:0] dn_wdata,
    output logic [ID_W-1:0]   dn_req_id,
    input  logic              cpl_valid,
    input  logic [1:0]        cpl_status,
    input  logic [DATA_W-1:0] cpl_data,
    input  logic [ID_W-1:0]   cpl_id,
    output logic              loc_sel,
    output logic              loc_write,
    output logic [REG_W-1:0]  loc_reg,
    output logic [DATA_W-1:0] loc_wdata,
    input  logic [DATA_W-1:0] loc_rdata,
    output logic              rsp_valid,
    output logic              rsp_ur,
    output logic [DATA_W-1:0] rsp_data,
    output logic [ID_W-1:0]   rsp_cpl_id
);
    localparam logic [DATA_W-1:0] ALL_ONES = '1;
    localparam logic [DATA_W-1:0] CRS_SHOW = {{(DATA_W-16){1'b1}}, 16'h0001};

    state_e             state, nxt;
    route_e             route, q_route;
    logic [1:0]         q_kind;
    logic               q_wr;
    logic [BUS_W-1:0]   q_bus;
    logic [DEV_W-1:0]   q_dev;
    logic [FN_W-1:0]    q_fn;
    logic [REG_W-1:0]   q_reg;
    logic [ADDR_W-1:0]  q_addr;
    logic [DATA_W-1:0]  q_wdata;
    logic [DATA_W-1:0]  rsp_data_q;
    logic               rsp_ur_q;
    logic [ID_W-1:0]    rsp_cid_q;
    logic [ID_W-1:0]    own_id;
    logic               cfg_read, posted, crs_show, crs_hidden;
    logic [1:0][WIN_W-1:0] wb, wl;

    assign own_id     = {own_bus, own_dev, own_fn};
    assign cfg_read   = q_kind[1] && !q_wr;
    assign posted     = (q_kind == K_MEM) && q_wr;
    assign crs_show   = crs_vis_en && cfg_read && (q_reg == '0);
    assign crs_hidden = cpl_valid && (cpl_st_e'(cpl_status) == C_CRS) && !crs_show;
    assign wb         = {pf_base, np_base};
    assign wl         = {pf_lim, np_lim};

    rp_decode #(
        .BUS_W(BUS_W), .DEV_W(DEV_W), .WIN_W(WIN_W), .N_WIN(2)
    ) u_dec (
        .kind    (q_kind),
        .write   (q_wr),
        .bus     (q_bus),
        .dev     (q_dev),
        .page    (q_addr[ADDR_W-1:GRAN]),
        .link_up (link_up),
        .sec_bus (sec_bus),
        .sub_bus (sub_bus),
        .win_base(wb),
        .win_lim (wl),
        .route   (route)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // next-state selection
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (req_valid) nxt = S_ROUTE;
            S_ROUTE: begin
                unique case (route)
                    RT_LOCAL:        nxt = S_LOCAL;
                    RT_FWD, RT_CONV: nxt = S_ISSUE;
                    default:         nxt = S_RESP;
                endcase
            end
            S_ISSUE: nxt = posted ? S_RESP : S_WAIT;
            S_WAIT:  if (cpl_valid) nxt = crs_hidden ? S_ISSUE : S_RESP;
            S_LOCAL: nxt = S_RESP;
            S_RESP:  nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // captured request and response datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_route    <= RT_UR;
            q_kind     <= '0;
            q_wr       <= 1'b0;
            q_bus      <= '0;
            q_dev      <= '0;
            q_fn       <= '0;
            q_reg      <= '0;
            q_addr     <= '0;
            q_wdata    <= '0;
            rsp_data_q <= '0;
            rsp_ur_q   <= 1'b0;
            rsp_cid_q  <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (req_valid) begin
                    q_kind  <= req_kind;
                    q_wr    <= req_write;
                    q_bus   <= req_bus;
                    q_dev   <= req_dev;
                    q_fn    <= req_fn;
                    q_reg   <= req_reg;
                    q_addr  <= req_addr;
                    q_wdata <= req_wdata;
                end
                S_ROUTE: begin
                    q_route    <= route;
                    rsp_data_q <= ALL_ONES;
                    rsp_ur_q   <= (route == RT_UR);
                    rsp_cid_q  <= own_id;
                end
                S_ISSUE: if (posted) begin
                    rsp_data_q <= '0;
                    rsp_ur_q   <= 1'b0;
                    rsp_cid_q  <= own_id;
                end
                S_WAIT: if (cpl_valid) begin
                    rsp_cid_q <= cpl_id;
                    unique case (cpl_st_e'(cpl_status))
                        C_SC: begin
                            rsp_data_q <= cpl_data;
                            rsp_ur_q   <= 1'b0;
                        end
                        C_CRS: begin
                            rsp_data_q <= CRS_SHOW;
                            rsp_ur_q   <= 1'b0;
                        end
                        default: begin
                            rsp_data_q <= ALL_ONES;
                            rsp_ur_q   <= !cfg_read;
                        end
                    endcase
                end
                S_LOCAL: begin
                    rsp_data_q <= loc_rdata;
                    rsp_ur_q   <= 1'b0;
                    rsp_cid_q  <= own_id;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready  = (state == S_IDLE);
        dn_valid   = (state == S_ISSUE);
        loc_sel    = (state == S_LOCAL);
        rsp_valid  = (state == S_RESP);
        dn_kind    = (q_route == RT_CONV) ? 2'(K_CFG0) : q_kind;
        dn_write   = q_wr;
        dn_bus     = q_bus;
        dn_dev     = q_dev;
        dn_fn      = q_fn;
        dn_reg     = q_reg;
        dn_addr    = q_addr;
        dn_wdata   = q_wdata;
        dn_req_id  = own_id;
        loc_write  = q_wr;
        loc_reg    = q_reg;
        loc_wdata  = q_wdata;
        rsp_ur     = rsp_ur_q;
        rsp_data   = rsp_data_q;
        rsp_cpl_id = rsp_cid_q;
    end
endmodule

// File: rtl/rp_route_chk.sv
module rp_route_chk #(
    parameter int BUS_W = 8,
    parameter int DEV_W = 5,
    parameter int WIN_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic [BUS_W-1:0] sec_bus,
    input logic [BUS_W-1:0] sub_bus,
    input logic [WIN_W-1:0] np_base,
    input logic [WIN_W-1:0] np_lim,
    input logic [WIN_W-1:0] pf_base,
    input logic [WIN_W-1:0] pf_lim,
    input logic             link_up,
    input logic             dn_valid,
    input logic [1:0]       dn_kind,
    input logic [BUS_W-1:0] dn_bus,
    input logic [DEV_W-1:0] dn_dev,
    input logic [WIN_W-1:0] dn_page,
    input logic             loc_sel,
    input logic             rsp_valid,
    input logic             req_ready
);
    logic in_win;
    assign in_win = ((dn_page >= np_base) && (dn_page <= np_lim)) ||
                    ((dn_page >= pf_base) && (dn_page <= pf_lim));

    a_r1_fwd_range: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && dn_kind == 2'b11) |-> ((dn_bus > sec_bus) && (dn_bus <= sub_bus)));

    a_r2_conv_target: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && dn_kind == 2'b10) |-> ((dn_bus == sec_bus) && (dn_dev == '0)));

    a_r3_local_answers: assert property (@(posedge clk) disable iff (!rst_n)
        loc_sel |=> rsp_valid);

    a_r4_mem_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && dn_kind == 2'b00) |-> in_win);

    a_r10_link_needed: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid |-> link_up);

    a_r13_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));
endmodule

bind rp_router rp_route_chk #(
    .BUS_W(BUS_W), .DEV_W(DEV_W), .WIN_W(WIN_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sec_bus  (sec_bus),
    .sub_bus  (sub_bus),
    .np_base  (np_base),
    .np_lim   (np_lim),
    .pf_base  (pf_base),
    .pf_lim   (pf_lim),
    .link_up  (link_up),
    .dn_valid (dn_valid),
    .dn_kind  (dn_kind),
    .dn_bus   (dn_bus),
    .dn_dev   (dn_dev),
    .dn_page  (dn_addr[ADDR_W-1:GRAN]),
    .loc_sel  (loc_sel),
    .rsp_valid(rsp_valid),
    .req_ready(req_ready)
);

// File: tb/rp_router_test.sv
module rp_router_test;
    localparam logic [31:0] ONES   = 32'hFFFF_FFFF;
    localparam logic [31:0] CPL_D  = 32'h5EED_1234;
    localparam logic [15:0] CPL_ID = 16'h0420;
    localparam logic [15:0] OWN_ID = 16'h011A;

    logic clk = 0, rst_n = 0;
    always #10 clk = ~clk;

    logic [7:0]  own_bus = 8'd1, sec_bus = 8'd3, sub_bus = 8'd6;
    logic [4:0]  own_dev = 5'd3;
    logic [2:0]  own_fn  = 3'd2;
    logic [11:0] np_base = 12'h100, np_lim = 12'h103, pf_base = 12'h200, pf_lim = 12'h200;
    logic        link_up = 1, crs_vis_en = 0;
    logic        req_valid = 0, req_write = 0;
    logic [1:0]  req_kind = 0;
    logic [7:0]  req_bus = 0;
    logic [4:0]  req_dev = 0;
    logic [2:0]  req_fn = 0;
    logic [9:0]  req_reg = 0;
    logic [31:0] req_addr = 0, req_wdata = 0;
    logic        cpl_valid = 0;
    logic [1:0]  cpl_status = 0;
    logic [31:0] cpl_data = CPL_D;
    logic [15:0] cpl_id = CPL_ID;
    logic [31:0] loc_rdata;

    logic        req_ready, dn_valid, dn_write, loc_sel, loc_write, rsp_valid, rsp_ur;
    logic [1:0]  dn_kind;
    logic [7:0]  dn_bus;
    logic [4:0]  dn_dev;
    logic [2:0]  dn_fn;
    logic [9:0]  dn_reg, loc_reg;
    logic [31:0] dn_addr, dn_wdata, loc_wdata, rsp_data;
    logic [15:0] dn_req_id, rsp_cpl_id;

    assign loc_rdata = {22'h2B3C1, loc_reg};

    rp_router uut (.*);

    int checks = 0, errors = 0;
    logic        g_rsp, g_ur;
    logic [31:0] g_data, g_daddr;
    logic [15:0] g_cid, g_drid;
    logic [1:0]  g_dkind;
    logic [7:0]  g_dbus;
    logic [4:0]  g_ddev;
    logic [9:0]  g_dreg;
    int          g_ndn, g_nloc;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_req(input logic [1:0] k, input logic w, input logic [7:0] b,
                           input logic [4:0] d, input logic [9:0] r, input logic [31:0] a,
                           input int n_crs, input logic [1:0] fin);
        int  crs_left = n_crs;
        bit  due = 0;
        bit  post = (k == 2'b00) && w;
        g_rsp = 0; g_ndn = 0; g_nloc = 0;
        @(negedge clk);
        req_valid = 1; req_kind = k; req_write = w; req_bus = b; req_dev = d;
        req_fn = 3'd4; req_reg = r; req_addr = a; req_wdata = 32'h0BAD_F00D;
        @(negedge clk);
        req_valid = 0;
        chk(!req_ready, "R13 busy", {31'd0, req_ready}, 0);
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            cpl_valid = 0;
            if (rsp_valid) begin
                g_rsp = 1; g_data = rsp_data; g_ur = rsp_ur; g_cid = rsp_cpl_id;
                break;
            end
            if (loc_sel) g_nloc++;
            if (dn_valid) begin
                g_ndn++; g_dkind = dn_kind; g_dbus = dn_bus; g_ddev = dn_dev;
                g_dreg = dn_reg; g_daddr = dn_addr; g_drid = dn_req_id;
                due = !post;
            end else if (due) begin
                due = 0;
                cpl_valid = 1;
                if (crs_left > 0) begin cpl_status = 2'b10; crs_left--; end
                else cpl_status = fin;
            end
        end
        chk(g_rsp, "R13 response", {31'd0, g_rsp}, 1);
        @(negedge clk);
        chk(!rsp_valid && req_ready, "R13 one-cycle pulse", {30'd0, rsp_valid, req_ready}, 1);
    endtask

    // common comparison of a completed request
    task automatic expect_rsp(input string tag, input int ndn, input logic [31:0] d,
                              input logic ur, input logic [15:0] cid);
        chk(g_ndn == ndn, {tag, " dn count"}, g_ndn, ndn);
        chk(g_data == d, {tag, " data"}, g_data, d);
        chk(g_ur == ur, {tag, " ur"}, {31'd0, g_ur}, {31'd0, ur});
        chk(g_cid == cid, {tag, " R7 cpl id"}, {16'd0, g_cid}, {16'd0, cid});
        if (ndn > 0) chk(g_drid == OWN_ID, "R7 requester id", {16'd0, g_drid}, {16'd0, OWN_ID});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(req_ready && !rsp_valid && !dn_valid && !loc_sel, "R13 reset state",
            {28'd0, req_ready, rsp_valid, dn_valid, loc_sel}, 32'h8);

        // Type 1 sweep over bus numbers around secondary and subordinate
        for (int b = 0; b < 10; b++) begin
            for (int dv = 0; dv < 3; dv += 2) begin
                run_req(2'b11, 0, 8'(b), 5'(dv), 10'd12, 0, 0, 2'b00);
                if (b == 3 && dv == 0) begin
                    expect_rsp("R2 convert", 1, CPL_D, 0, CPL_ID);
                    chk(g_dkind == 2'b10 && g_dbus == 8'(b) && g_dreg == 10'd12,
                        "R2 type0 fields", {g_dkind, g_dbus, g_dreg}, {2'b10, 8'(b), 10'd12});
                end else if (b == 3) begin
                    expect_rsp("R8 missing device", 0, ONES, 0, OWN_ID);
                end else if (b > 3 && b <= 6) begin
                    expect_rsp("R1 forward", 1, CPL_D, 0, CPL_ID);
                    chk(g_dkind == 2'b11 && g_dbus == 8'(b) && g_ddev == 5'(dv),
                        "R1 type1 fields", {g_dkind, g_dbus, g_ddev}, {2'b11, 8'(b), 5'(dv)});
                end else begin
                    expect_rsp("R6 out of range", 0, ONES, 1, OWN_ID);
                end
            end
        end
        run_req(2'b11, 1, 8'd3, 5'd2, 10'd1, 0, 0, 2'b00);
        expect_rsp("R8 missing device write", 0, ONES, 1, OWN_ID);

        // Type 0 local claims
        for (int r = 0; r < 4; r++) begin
            run_req(2'b10, 0, 8'd3, 5'd0, 10'(r * 37), 0, 0, 2'b00);
            expect_rsp("R3 local", 0, {22'h2B3C1, 10'(r * 37)}, 0, OWN_ID);
            chk(g_nloc == 1, "R3 loc_sel once", g_nloc, 1);
        end

        // Memory window sweep
        begin
            logic [11:0] pages [8] = '{12'h0FF, 12'h100, 12'h102, 12'h103,
                                       12'h104, 12'h1FF, 12'h200, 12'h201};
            for (int i = 0; i < 8; i++) begin
                for (int w = 0; w < 2; w++) begin
                    logic [31:0] a = {pages[i], 20'hABCDE};
                    bit hit = (pages[i] >= 12'h100 && pages[i] <= 12'h103) || pages[i] == 12'h200;
                    run_req(2'b00, w[0], 0, 0, 0, a, 0, 2'b00);
                    if (!hit) expect_rsp("R5 outside windows", 0, ONES, 1, OWN_ID);
                    else if (w == 0) begin
                        expect_rsp("R4 mem read", 1, CPL_D, 0, CPL_ID);
                        chk(g_daddr == a && g_dkind == 2'b00, "R4 mem addr", g_daddr, a);
                    end else expect_rsp("R4 posted write", 1, 32'd0, 0, OWN_ID);
                end
            end
        end

        // Downstream Unsupported Request
        run_req(2'b11, 0, 8'd5, 5'd1, 10'd2, 0, 0, 2'b01);
        expect_rsp("R9 cfg read UR", 1, ONES, 0, CPL_ID);
        run_req(2'b11, 1, 8'd5, 5'd1, 10'd2, 0, 0, 2'b01);
        expect_rsp("R9 cfg write UR", 1, ONES, 1, CPL_ID);
        run_req(2'b00, 0, 0, 0, 0, 32'h1010_0000, 0, 2'b01);
        expect_rsp("R9 mem read UR", 1, ONES, 1, CPL_ID);

        // Retry status
        crs_vis_en = 1;
        run_req(2'b11, 0, 8'd4, 5'd0, 10'd0, 0, 1, 2'b00);
        expect_rsp("R11 visible retry", 1, 32'hFFFF_0001, 0, CPL_ID);
        run_req(2'b11, 0, 8'd4, 5'd0, 10'd4, 0, 1, 2'b00);
        expect_rsp("R12 retry non-vendor reg", 2, CPL_D, 0, CPL_ID);
        crs_vis_en = 0;
        run_req(2'b11, 0, 8'd3, 5'd0, 10'd0, 0, 2, 2'b00);
        expect_rsp("R12 retry hidden", 3, CPL_D, 0, CPL_ID);

        // Link down
        link_up = 0;
        run_req(2'b11, 0, 8'd4, 5'd0, 10'd0, 0, 0, 2'b00);
        expect_rsp("R10 link down read", 0, ONES, 0, OWN_ID);
        run_req(2'b11, 0, 8'd3, 5'd0, 10'd0, 0, 0, 2'b00);
        expect_rsp("R10 link down secondary read", 0, ONES, 0, OWN_ID);
        run_req(2'b11, 1, 8'd4, 5'd0, 10'd0, 0, 0, 2'b00);
        expect_rsp("R10 link down write", 0, ONES, 1, OWN_ID);
        run_req(2'b00, 0, 0, 0, 0, 32'h1000_0000, 0, 2'b00);
        expect_rsp("R10 link down mem", 0, ONES, 1, OWN_ID);
        run_req(2'b10, 0, 8'd0, 5'd0, 10'd9, 0, 0, 2'b00);
        expect_rsp("R10 R3 local while down", 0, {22'h2B3C1, 10'd9}, 0, OWN_ID);
        link_up = 1;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule